// File: doc/BRIEF.md
# Configuration Store Controller with Security Lock

This block is the programming-port controller for the configuration memory of a small programmable logic device. It holds the connection-bit array that sets the product terms, one extra row of output-cell configuration bits, a security flag and a signature word. A programmer drives single-cycle commands over a valid/command/address/data handshake. The block answers with a one-cycle completion pulse, an error flag and a registered read-data word.

Bulk erase sweeps the storage one row per cycle and holds busy high for the whole sweep. Commands are ignored while busy is high. Once security is set, the array can be neither read nor written, and the signature cannot be rewritten. The signature stays readable. A full bulk erase is the only way to clear security and restore access. The signature is 64 bits wide or, in narrow mode, 24 bits wide.

Top module: `cfg_store_ctrl`

## Requirements
- R1: After reset, busy_o, done_o, err_o and secure_o are low, and rdata_o and cfg_o are zero. Every array bit reads back as 0.
- R2: A command is taken when cmd_valid_i is high and busy_o is low. The cmd_i codes are: 0 idle, 1 erase, 2 program bit, 3 read bit, 4 lock, 5 program bit and lock, 6 write signature, 7 read signature. Code 0 gives no response. Codes 2 to 7 pulse done_o in the cycle after acceptance, with err_o set only when the command is refused.
- R3: addr_i is {row, column}, with the column in the low log2(COLS) bits. Programming stores bit_i at that position. A read returns the bit in rdata_o[0], with all other bits zero. Row ROWS is the output-cell configuration row, and it appears on cfg_o.
- R4: An erase keeps busy_o high for ROWS+1 cycles after the accepting edge and then pulses done_o. Any command offered while busy_o is high is ignored and changes no storage.
- R5: When an erase completes, every array bit, the configuration row, the signature and the security flag are zero.
- R6: Lock (code 4) sets secure_o in the cycle after acceptance. Program-and-lock (code 5) writes its bit and sets secure_o in the same step.
- R7: While secure_o is high, program, program-and-lock and signature-write commands are refused with err_o and leave all storage unchanged.
- R8: While secure_o is high, a bit read is refused with err_o and rdata_o becomes all zeros.
- R9: A signature read succeeds whether or not secure_o is high.
- R10: With sig_wide_i high, the signature is 64 bits. With it low, only bits 23:0 are stored and returned, and bits 63:24 of the read data are zero.
- R11: A program or read whose row field exceeds ROWS is refused with err_o. A refused read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 3 | Command code |
| addr_i | input | ADDR_W (8) | Row and column of the bit |
| bit_i | input | 1 | Bit value to program |
| sig_i | input | 64 | Signature value to write |
| sig_wide_i | input | 1 | Signature width mode, 1 = 64 bits, 0 = 24 bits |
| busy_o | output | 1 | Erase sweep in progress |
| done_o | output | 1 | Command completed (one cycle) |
| err_o | output | 1 | Completed command was refused |
| rdata_o | output | 64 | Result of the last read command |
| secure_o | output | 1 | Security lock state |
| cfg_o | output | COLS (16) | Output-cell configuration row |

## Verification
The assertions assume that cmd_i and addr_i are known whenever cmd_valid_i is high. They also assume that sig_wide_i does not change in the cycle a signature read is taken. The stimulus drives every input on the falling clock edge and raises cmd_valid_i for one cycle per command. It changes sig_wide_i only while no command is pending. During an erase sweep it offers a program command on purpose, so that the ignore rule is exercised at a point where that row has already been cleared.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;
  typedef enum logic [2:0] {
    CMD_NOP       = 3'd0,
    CMD_ERASE     = 3'd1,
    CMD_PROG      = 3'd2,
    CMD_READ      = 3'd3,
    CMD_LOCK      = 3'd4,
    CMD_PROG_LOCK = 3'd5,
    CMD_SIG_WR    = 3'd6,
    CMD_SIG_RD    = 3'd7
  } cmd_e;

  localparam int SIG_W        = 64;
  localparam int SIG_NARROW_W = 24;
endpackage

// File: rtl/cfg_cmd_fsm.sv
module cfg_cmd_fsm
  import cfg_store_pkg::*;
#(
  parameter int NROWS = 9,
  parameter int ROW_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  cmd_e             cmd_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             secure_i,
  output logic             busy_o,
  output logic             clr_en_o,
  output logic [ROW_W-1:0] clr_row_o,
  output logic             erase_end_o,
  output logic             wr_en_o,
  output logic             rd_req_o,
  output logic             sig_wr_o,
  output logic             sig_rd_o,
  output logic             lock_set_o,
  output logic             refuse_o,
  output logic             done_o,
  output logic             err_o
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NROWS - 1);

  logic             busy_q, done_q, err_q;
  logic [ROW_W-1:0] ptr_q;
  logic             accept, is_arr, row_ok, ok;

  assign accept = cmd_valid_i && !busy_q;
  assign is_arr = (cmd_i == CMD_PROG) || (cmd_i == CMD_READ) || (cmd_i == CMD_PROG_LOCK);
  assign row_ok = row_i <= LAST_ROW;
  assign refuse_o = accept && ((is_arr && (secure_i || !row_ok)) ||
                               ((cmd_i == CMD_SIG_WR) && secure_i));
  assign ok = accept && !refuse_o;

  assign wr_en_o    = ok && ((cmd_i == CMD_PROG) || (cmd_i == CMD_PROG_LOCK));
  assign rd_req_o   = accept && (cmd_i == CMD_READ);
  assign sig_wr_o   = ok && (cmd_i == CMD_SIG_WR);
  assign sig_rd_o   = accept && (cmd_i == CMD_SIG_RD);
  assign lock_set_o = ok && ((cmd_i == CMD_LOCK) || (cmd_i == CMD_PROG_LOCK));

  assign clr_en_o    = busy_q;
  assign clr_row_o   = ptr_q;
  assign erase_end_o = busy_q && (ptr_q == LAST_ROW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (busy_q) begin
        if (ptr_q == LAST_ROW) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          ptr_q <= ptr_q + 1'b1;
        end
      end else if (accept) begin
        if (cmd_i == CMD_ERASE) begin
          busy_q <= 1'b1;
          ptr_q  <= '0;
        end else if (cmd_i != CMD_NOP) begin
          done_q <= 1'b1;
          err_q  <= refuse_o;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/cfg_bit_array.sv
module cfg_bit_array #(
  parameter int NROWS = 9,
  parameter int COLS  = 16,
  parameter int ROW_W = 4,
  parameter int COL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [ROW_W-1:0] wr_row_i,
  input  logic [COL_W-1:0] wr_col_i,
  input  logic             wr_bit_i,
  input  logic             clr_en_i,
  input  logic [ROW_W-1:0] clr_row_i,
  input  logic [ROW_W-1:0] rd_row_i,
  input  logic [COL_W-1:0] rd_col_i,
  output logic             rd_bit_o,
  output logic [COLS-1:0]  cfg_row_o
);
  localparam int PAD_ROWS = 2 ** ROW_W;

  logic [COLS-1:0] rows [PAD_ROWS];

  for (genvar r = 0; r < PAD_ROWS; r++) begin : g_row
    if (r < NROWS) begin : g_live
      logic [COLS-1:0] row_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          row_q <= '0;
        end else if (clr_en_i && (clr_row_i == ROW_W'(r))) begin
          row_q <= '0;
        end else if (wr_en_i && (wr_row_i == ROW_W'(r))) begin
          row_q[wr_col_i] <= wr_bit_i;
        end
      end
      assign rows[r] = row_q;
    end else begin : g_pad
      assign rows[r] = '0;
    end
  end

  assign rd_bit_o  = rows[rd_row_i][rd_col_i];
  assign cfg_row_o = rows[NROWS-1];
endmodule

// File: rtl/cfg_sig_reg.sv
module cfg_sig_reg #(
  parameter int SIG_W    = 64,
  parameter int NARROW_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [SIG_W-1:0] data_i,
  input  logic             clr_i,
  input  logic             wide_i,
  output logic [SIG_W-1:0] sig_o
);
  localparam logic [SIG_W-1:0] NARROW_MASK = {{(SIG_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [SIG_W-1:0] sig_q, mask;

  assign mask = wide_i ? '1 : NARROW_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sig_q <= '0;
    else if (clr_i)  sig_q <= '0;
    else if (wr_i)   sig_q <= data_i & mask;
  end

  assign sig_o = sig_q & mask;
endmodule

// File: rtl/cfg_store_ctrl.sv
module cfg_store_ctrl
  import cfg_store_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 16,
  localparam int NROWS  = ROWS + 1,
  localparam int ROW_W  = $clog2(NROWS + 1),
  localparam int COL_W  = $clog2(COLS),
  localparam int ADDR_W = ROW_W + COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              bit_i,
  input  logic [SIG_W-1:0]  sig_i,
  input  logic              sig_wide_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [SIG_W-1:0]  rdata_o,
  output logic              secure_o,
  output logic [COLS-1:0]   cfg_o
);
  logic [ROW_W-1:0] row, clr_row;
  logic [COL_W-1:0] col;
  logic clr_en, erase_end, wr_en, rd_req, sig_wr, sig_rd, lock_set, refuse, rd_bit;
  logic secure_q;
  logic [SIG_W-1:0] sig_val, rdata_q;

  assign row = addr_i[ADDR_W-1:COL_W];
  assign col = addr_i[COL_W-1:0];

  cfg_cmd_fsm #(.NROWS(NROWS), .ROW_W(ROW_W)) u_fsm (
    .clk_i, .rst_ni, .cmd_valid_i,
    .cmd_i       (cmd_e'(cmd_i)),
    .row_i       (row),
    .secure_i    (secure_q),
    .busy_o,
    .clr_en_o    (clr_en),
    .clr_row_o   (clr_row),
    .erase_end_o (erase_end),
    .wr_en_o     (wr_en),
    .rd_req_o    (rd_req),
    .sig_wr_o    (sig_wr),
    .sig_rd_o    (sig_rd),
    .lock_set_o  (lock_set),
    .refuse_o    (refuse),
    .done_o,
    .err_o
  );

  cfg_bit_array #(.NROWS(NROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)) u_array (
    .clk_i, .rst_ni,
    .wr_en_i   (wr_en),
    .wr_row_i  (row),
    .wr_col_i  (col),
    .wr_bit_i  (bit_i),
    .clr_en_i  (clr_en),
    .clr_row_i (clr_row),
    .rd_row_i  (row),
    .rd_col_i  (col),
    .rd_bit_o  (rd_bit),
    .cfg_row_o (cfg_o)
  );

  cfg_sig_reg #(.SIG_W(SIG_W), .NARROW_W(SIG_NARROW_W)) u_sig (
    .clk_i, .rst_ni,
    .wr_i   (sig_wr),
    .data_i (sig_i),
    .clr_i  (erase_end),
    .wide_i (sig_wide_i),
    .sig_o  (sig_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        secure_q <= 1'b0;
    else if (erase_end) secure_q <= 1'b0;
    else if (lock_set)  secure_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_req) rdata_q <= refuse ? '0 : {{(SIG_W-1){1'b0}}, rd_bit};
    else if (sig_rd) rdata_q <= sig_val;
  end

  assign secure_o = secure_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/cfg_store_chk.sv
module cfg_store_chk
  import cfg_store_pkg::*;
#(
  parameter int COLS = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic [2:0]       cmd_i,
  input logic             sig_wide_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o,
  input logic [SIG_W-1:0] rdata_o,
  input logic             secure_o,
  input logic [COLS-1:0]  cfg_o
);
  logic take;
  assign take = cmd_valid_i && !busy_o;

  assert_err_with_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  assert_busy_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !err_o);

  assert_erase_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (cfg_o == '0) && !secure_o && done_o);

  assert_lock_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && (cmd_i == CMD_LOCK) |=> secure_o);

  assert_write_refused_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && secure_o && ((cmd_i == CMD_PROG) || (cmd_i == CMD_PROG_LOCK) || (cmd_i == CMD_SIG_WR))
    |=> done_o && err_o && $stable(cfg_o));

  assert_read_blank_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && secure_o && (cmd_i == CMD_READ) |=> err_o && (rdata_o == '0));

  assert_sig_open_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && (cmd_i == CMD_SIG_RD) |=> done_o && !err_o);

  assert_narrow_sig_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && (cmd_i == CMD_SIG_RD) && !sig_wide_i |=> (rdata_o[SIG_W-1:SIG_NARROW_W] == '0));

  assert_unlock_only_erase_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(secure_o) |-> done_o && $past(busy_o));
endmodule

bind cfg_store_ctrl cfg_store_chk #(.COLS(COLS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_i       (cmd_i),
  .sig_wide_i  (sig_wide_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .rdata_o     (rdata_o),
  .secure_o    (secure_o),
  .cfg_o       (cfg_o)
);

// File: tb/cfg_store_ctrl_bench.sv
module cfg_store_ctrl_bench;
  localparam int ROWS   = 8;
  localparam int COLS   = 16;
  localparam int ADDR_W = 8;

  localparam logic [2:0] C_ERASE = 3'd1, C_PROG = 3'd2, C_READ = 3'd3, C_LOCK = 3'd4,
                         C_PLOCK = 3'd5, C_SWR = 3'd6, C_SRD = 3'd7;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic [2:0]        cmd = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic              bit_in = 1'b0;
  logic [63:0]       sig = '0;
  logic              sig_wide = 1'b1;
  logic              busy, done, err, secure;
  logic [63:0]       rdata;
  logic [COLS-1:0]   cfg;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  cfg_store_ctrl #(.ROWS(ROWS), .COLS(COLS)) u_cfg_store_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd), .addr_i(addr),
    .bit_i(bit_in), .sig_i(sig), .sig_wide_i(sig_wide), .busy_o(busy), .done_o(done),
    .err_o(err), .rdata_o(rdata), .secure_o(secure), .cfg_o(cfg)
  );

  function automatic logic [ADDR_W-1:0] at(input int r, input int c);
    return {4'(r), 4'(c)};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] c, input logic [ADDR_W-1:0] a, input logic b,
                       input logic [63:0] s);
    cmd_valid = 1'b1; cmd = c; addr = a; bit_in = b; sig = s;
    @(negedge clk);
    cmd_valid = 1'b0; cmd = '0;
  endtask

  task automatic t_reset;
    chk("R1 busy", 64'(busy), 0);
    chk("R1 secure", 64'(secure), 0);
    chk("R1 cfg", 64'(cfg), 0);
    chk("R1 rdata", rdata, 0);
    chk("R1 done", 64'(done), 0);
    issue(C_READ, at(2, 9), 0, 0);
    chk("R1 read bit", rdata, 0);
  endtask

  task automatic t_prog_read;
    issue(C_PROG, at(0, 3), 1, 0);
    chk("R2 prog done", {62'b0, done, err}, 64'b10);
    issue(C_READ, at(0, 3), 0, 0);
    chk("R3 read one", rdata, 64'd1);
    chk("R2 read done", {62'b0, done, err}, 64'b10);
    issue(C_READ, at(0, 4), 0, 0);
    chk("R3 read neighbour", rdata, 0);
    issue(C_PROG, at(ROWS, 5), 1, 0);
    chk("R3 cfg row", 64'(cfg), 64'(16'h0020));
    issue(3'd0, at(0, 3), 0, 0);
    chk("R2 idle no done", 64'(done), 0);
  endtask

  task automatic t_bad_row;
    issue(C_PROG, at(ROWS + 1, 2), 1, 0);
    chk("R11 prog refused", {62'b0, done, err}, 64'b11);
    issue(C_READ, at(ROWS + 1, 2), 0, 0);
    chk("R11 read refused", {62'b0, done, err}, 64'b11);
    chk("R11 read zero", rdata, 0);
  endtask

  task automatic t_sig;
    sig_wide = 1'b1;
    issue(C_SWR, 0, 0, 64'hDEAD_BEEF_CAFE_F00D);
    issue(C_SRD, 0, 0, 0);
    chk("R10 wide read", rdata, 64'hDEAD_BEEF_CAFE_F00D);
    sig_wide = 1'b0;
    @(negedge clk);
    issue(C_SRD, 0, 0, 0);
    chk("R10 narrow view", rdata, 64'h0000_0000_00FE_F00D);
    issue(C_SWR, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    sig_wide = 1'b1;
    @(negedge clk);
    issue(C_SRD, 0, 0, 0);
    chk("R10 narrow write", rdata, 64'h0000_0000_00FF_FFFF);
  endtask

  task automatic t_lock;
    issue(C_LOCK, 0, 0, 0);
    chk("R6 lock", {61'b0, secure, done, err}, 64'b110);
    issue(C_PROG, at(ROWS, 9), 1, 0);
    chk("R7 prog refused", {62'b0, done, err}, 64'b11);
    chk("R7 cfg kept", 64'(cfg), 64'(16'h0020));
    issue(C_PLOCK, at(ROWS, 1), 1, 0);
    chk("R7 prog-lock refused", {46'b0, cfg, done, err}, {46'b0, 16'h0020, 2'b11});
    issue(C_READ, at(0, 3), 0, 0);
    chk("R8 read refused", {62'b0, done, err}, 64'b11);
    chk("R8 read blank", rdata, 0);
    issue(C_SWR, 0, 0, 64'h1234);
    chk("R7 sig write refused", 64'(err), 1);
    issue(C_SRD, 0, 0, 0);
    chk("R9 sig readable", rdata, 64'h0000_0000_00FF_FFFF);
    chk("R9 sig no err", 64'(err), 0);
  endtask

  task automatic t_erase;
    int cnt = 0;
    bit early_done = 0;
    issue(C_ERASE, 0, 0, 0);
    while (busy && cnt < 100) begin
      if (done) early_done = 1;
      if (cnt == 3) begin
        cmd_valid = 1'b1; cmd = C_PROG; addr = at(0, 7); bit_in = 1'b1;
      end
      @(negedge clk);
      cmd_valid = 1'b0; cmd = '0;
      cnt++;
    end
    chk("R4 busy length", 64'(cnt), 64'(ROWS + 1));
    chk("R4 no early done", 64'(early_done), 0);
    chk("R4 done at end", 64'(done), 1);
    chk("R5 secure cleared", 64'(secure), 0);
    chk("R5 cfg cleared", 64'(cfg), 0);
    issue(C_READ, at(0, 3), 0, 0);
    chk("R5 bit cleared", {rdata[62:0], err}, 0);
    issue(C_READ, at(0, 7), 0, 0);
    chk("R4 busy command ignored", rdata, 0);
    issue(C_SRD, 0, 0, 0);
    chk("R5 sig cleared", rdata, 0);
  endtask

  task automatic t_prog_lock;
    issue(C_PLOCK, at(ROWS, 0), 1, 0);
    chk("R6 prog-lock ok", {61'b0, secure, done, err}, 64'b110);
    chk("R6 prog-lock wrote", 64'(cfg), 1);
    issue(C_READ, at(ROWS, 0), 0, 0);
    chk("R8 locked after prog-lock", {rdata[62:0], err}, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prog_read();
    t_bad_row();
    t_sig();
    t_lock();
    t_erase();
    t_prog_lock();
    t_erase();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule